// File: doc/BRIEF.md
# Guest External Interrupt Enable/Pending Unit

This block keeps the two hypervisor registers that track guest external interrupts on a hart with hypervisor support. One register holds the enable bits and one the pending bits. An external interrupt controller drives one level-sensitive line per guest interrupt file. The unit registers those levels into the pending register and combines them with the enable register. From that it produces the supervisor-level guest external pending bit, which feeds the hart's interrupt pending register.

A selector field from the hypervisor status register chooses one pending bit. That bit is the virtual-supervisor external interrupt contribution. The surrounding CSR file ORs it into the external-pending position of the pending view. It does so for every read path except the one through the hypervisor virtual pending register; the unit is told which path is in use and gates the view output to match. Bit 0 of both registers is never implemented. The count of implemented bits is a parameter, clamped to XLEN-1.

Top module: `guest_ext_irq_unit`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), the enable and pending registers read zero, and `sgeip_o`, `vseip_raw_o` and `vseip_view_o` are low.
- R2: A write to the enable register (`csr_addr_i` = 0) stores the write data masked to bits 1..GEILEN. Bit 0 and every bit above GEILEN read back as zero. The stored value is visible on `csr_rdata_o` from the clock edge that takes the write.
- R3: The pending register (`csr_addr_i` = 1) cannot be written: a write to it leaves its read value unchanged.
- R4: Guest line k drives pending bit k+1. Each bit takes its line's level at the first rising clock edge after the change, and it follows both rising and falling levels.
- R5: `sgeip_o` is high exactly when the AND of the enable and pending registers is nonzero. It reacts in the same cycle as a register update, whether that update comes from an enable write or from a line.
- R6: `vseip_raw_o` equals the pending bit indexed by `vgein_i` when `vgein_i` is between 1 and GEILEN. For 0 or for any value above GEILEN it is zero.
- R7: `vseip_view_o` equals `vseip_raw_o` when `view_hvip_i` is low, and is zero when `view_hvip_i` is high.
- R8: While `hyp_en_i` is low, `geilen_o` reads zero and the pending register clears and stays zero whatever the lines do. An enable write then stores zero.
- R9: With hypervisor support on, `geilen_o` reads the implemented count, which is min(NUM_GUEST, XLEN-1). Lines beyond that count have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| hyp_en_i | input | 1 | Hypervisor support enabled |
| guest_irq_i | input | NUM_GUEST | Level-sensitive guest interrupt lines, line k to pending bit k+1 |
| csr_we_i | input | 1 | Register write strobe |
| csr_addr_i | input | 1 | 0 selects enable, 1 selects pending |
| csr_wdata_i | input | XLEN | Write data |
| csr_rdata_o | output | XLEN | Read data of the selected register |
| vgein_i | input | $clog2(XLEN) | Guest interrupt selector from the hypervisor status register |
| view_hvip_i | input | 1 | Pending view is being read through the hypervisor virtual pending register |
| geilen_o | output | $clog2(XLEN) | Implemented guest line count, zero when hypervisor support is off |
| sgeip_o | output | 1 | Supervisor guest external interrupt pending |
| vseip_raw_o | output | 1 | Selected pending bit |
| vseip_view_o | output | 1 | Selected bit as seen by the pending view for the current read path |

## Verification
The hardest case to reach is the clamp on the line count. It shows only when NUM_GUEST is larger than XLEN-1, which the default parameters never produce. The bench therefore runs a second instance with an 8-bit register width and ten lines. It raises every line, then checks that the pending register and the enable mask both stop at bit 7 and that the count reads 7. A second hard case is the exact edge at which a line change becomes visible. The bench checks the pending register after changing a line but before the next clock edge, and again just after that edge.

// File: rtl/gei_pkg.sv
// Package: shared constants and helpers for the guest external interrupt unit.
// Assumes XLEN >= 2 so that at least one guest bit can exist.
package gei_pkg;

    // Register select encoding on the CSR port
    localparam logic GEI_SEL_ENABLE  = 1'b0;
    localparam logic GEI_SEL_PENDING = 1'b1;

    // Number of implemented guest bits: the request clamped to XLEN-1
    function automatic int unsigned gei_clamp(input int unsigned req, input int unsigned xlen);
        return (req > xlen - 1) ? (xlen - 1) : req;
    endfunction

endpackage

// File: rtl/gei_enable_reg.sv
// Module: guest interrupt enable register.
// Stores write data masked to bits 1..GEILEN. When hypervisor support is off,
// the mask is empty and a write stores zero. Assumes GEILEN <= XLEN-1.
module gei_enable_reg #(
    parameter int unsigned XLEN   = 64,
    parameter int unsigned GEILEN = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hyp_en,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] en_q
);
    localparam logic [XLEN-1:0] ONE  = {{(XLEN-1){1'b0}}, 1'b1};
    localparam logic [XLEN-1:0] IMPL = ((ONE << GEILEN) - ONE) << 1;

    logic [XLEN-1:0] wmask;

    // Writable bits for the current configuration
    always_comb wmask = hyp_en ? IMPL : '0;

    // Enable register update
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else if (wr_en)
            en_q <= wdata & wmask;
    end

    // R2: bit 0 never becomes set
    p_bit0_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> en_q[0] == 1'b0);
    // R2: without a write the register holds
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(en_q));
    // R8: write with hypervisor support off stores zero
    p_off_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hyp_en) |=> en_q == '0);

endmodule

// File: rtl/gei_pending_sync.sv
// Module: guest interrupt pending register.
// Registers line k into bit k+1 every cycle. Bit 0 and bits above GEILEN stay
// zero. Lines at index GEILEN and above are ignored. Assumes GEILEN <= NUM_LINES.
module gei_pending_sync #(
    parameter int unsigned XLEN      = 64,
    parameter int unsigned NUM_LINES = 8,
    parameter int unsigned GEILEN    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hyp_en,
    input  logic [NUM_LINES-1:0] lines,
    output logic [XLEN-1:0]      pend_q
);
    logic [XLEN-1:0] pend_d;

    // Map implemented lines onto bits 1..GEILEN
    always_comb begin
        pend_d = '0;
        for (int k = 0; k < int'(GEILEN); k++)
            pend_d[k+1] = hyp_en & lines[k];
    end

    // Pending register sampling
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= '0;
        else
            pend_q <= pend_d;
    end

    // R4: each implemented bit follows its line one edge later
    for (genvar g = 0; g < int'(GEILEN); g++) begin : g_follow
        p_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
            hyp_en |=> pend_q[g+1] == $past(lines[g]));
    end

    // R8: hypervisor support off clears the register
    p_off_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !hyp_en |=> pend_q == '0);

endmodule

// File: rtl/gei_vs_select.sv
// Module: picks the pending bit addressed by the selector field.
// A selector of 0 or above GEILEN addresses an unimplemented bit and yields 0.
module gei_vs_select #(
    parameter int unsigned XLEN   = 64,
    parameter int unsigned GEILEN = 8,
    parameter int unsigned SEL_W  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [XLEN-1:0]  pend,
    input  logic [SEL_W-1:0] sel,
    output logic             sel_bit
);
    logic in_range;

    // Selector addresses an implemented bit
    always_comb in_range = (sel != '0) && (sel <= SEL_W'(GEILEN));

    // Selected bit
    always_comb sel_bit = in_range ? pend[sel] : 1'b0;

    // R6: selector 0 never yields a bit
    p_sel_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == '0) |-> !sel_bit);
    // R6: selector beyond the implemented count never yields a bit
    p_sel_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel > SEL_W'(GEILEN)) |-> !sel_bit);

endmodule

// File: rtl/guest_ext_irq_unit.sv
// Module: guest external interrupt enable/pending unit (top).
// Holds the enable and pending registers and offers a read/write port for
// them. Drives the supervisor guest pending summary and the selected bit for
// the virtual-supervisor external pending view. Assumes XLEN is a power of two.
module guest_ext_irq_unit #(
    parameter int unsigned XLEN      = 64,
    parameter int unsigned NUM_GUEST = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     hyp_en_i,
    input  logic [NUM_GUEST-1:0]     guest_irq_i,
    input  logic                     csr_we_i,
    input  logic                     csr_addr_i,
    input  logic [XLEN-1:0]          csr_wdata_i,
    output logic [XLEN-1:0]          csr_rdata_o,
    input  logic [$clog2(XLEN)-1:0]  vgein_i,
    input  logic                     view_hvip_i,
    output logic [$clog2(XLEN)-1:0]  geilen_o,
    output logic                     sgeip_o,
    output logic                     vseip_raw_o,
    output logic                     vseip_view_o
);
    import gei_pkg::*;

    localparam int unsigned SEL_W  = $clog2(XLEN);
    localparam int unsigned GEILEN = gei_clamp(NUM_GUEST, XLEN);

    logic [XLEN-1:0] en_q;
    logic [XLEN-1:0] pend_q;
    logic            en_wr;
    logic            sel_bit;

    // Enable write strobe; pending writes are dropped here
    always_comb en_wr = csr_we_i && (csr_addr_i == GEI_SEL_ENABLE);

    gei_enable_reg #(.XLEN(XLEN), .GEILEN(GEILEN)) u_en (
        .clk(clk), .rst_n(rst_n), .hyp_en(hyp_en_i),
        .wr_en(en_wr), .wdata(csr_wdata_i), .en_q(en_q)
    );

    gei_pending_sync #(.XLEN(XLEN), .NUM_LINES(NUM_GUEST), .GEILEN(GEILEN)) u_pend (
        .clk(clk), .rst_n(rst_n), .hyp_en(hyp_en_i),
        .lines(guest_irq_i), .pend_q(pend_q)
    );

    gei_vs_select #(.XLEN(XLEN), .GEILEN(GEILEN), .SEL_W(SEL_W)) u_sel (
        .clk(clk), .rst_n(rst_n), .pend(pend_q), .sel(vgein_i), .sel_bit(sel_bit)
    );

    // Read mux
    always_comb csr_rdata_o = (csr_addr_i == GEI_SEL_PENDING) ? pend_q : en_q;

    // Supervisor guest external pending summary
    always_comb sgeip_o = |(en_q & pend_q);

    // Selected bit and its gated view
    always_comb begin
        vseip_raw_o  = sel_bit;
        vseip_view_o = sel_bit & ~view_hvip_i;
    end

    // Implemented count as seen by software
    always_comb geilen_o = hyp_en_i ? SEL_W'(GEILEN) : '0;

    // R1: registers empty right after reset
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (en_q == '0 && pend_q == '0));
    // R3: a pending-register write never changes the enable register
    p_pend_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we_i && csr_addr_i == GEI_SEL_PENDING) |=> $stable(en_q));
    // R5: summary needs both an enable and a pending bit
    p_sgeip_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sgeip_o |-> (en_q != '0 && pend_q != '0));
    // R7: read through hypervisor virtual pending omits the bit
    p_view_hvip_r7: assert property (@(posedge clk) disable iff (!rst_n)
        view_hvip_i |-> !vseip_view_o);
    // R7: other read paths carry the bit
    p_view_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!view_hvip_i && vseip_raw_o) |-> vseip_view_o);
    // R8: count reads zero without hypervisor support
    p_geilen_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !hyp_en_i |-> geilen_o == '0);

endmodule

// File: tb/sim_guest_ext_irq_unit.sv
module sim_guest_ext_irq_unit;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    // default instance: XLEN 64, 8 lines
    logic        hyp0 = 1'b1;
    logic [7:0]  irq0 = '0;
    logic        we0 = 1'b0;
    logic        addr0 = 1'b0;
    logic [63:0] wd0 = '0;
    logic [63:0] rd0;
    logic [5:0]  vg0 = '0;
    logic        hv0 = 1'b0;
    logic [5:0]  gl0;
    logic        sge0, vraw0, vview0;

    // clamp instance: XLEN 8, 10 lines
    logic [9:0]  irq1 = '0;
    logic        we1 = 1'b0;
    logic        addr1 = 1'b0;
    logic [7:0]  wd1 = '0;
    logic [7:0]  rd1;
    logic [2:0]  gl1;
    logic        sge1, vraw1, vview1;

    always #(CLK_P/2) clk = ~clk;

    guest_ext_irq_unit #(.XLEN(64), .NUM_GUEST(8)) u0 (
        .clk(clk), .rst_n(rst_n), .hyp_en_i(hyp0), .guest_irq_i(irq0),
        .csr_we_i(we0), .csr_addr_i(addr0), .csr_wdata_i(wd0), .csr_rdata_o(rd0),
        .vgein_i(vg0), .view_hvip_i(hv0), .geilen_o(gl0), .sgeip_o(sge0),
        .vseip_raw_o(vraw0), .vseip_view_o(vview0)
    );

    guest_ext_irq_unit #(.XLEN(8), .NUM_GUEST(10)) u1 (
        .clk(clk), .rst_n(rst_n), .hyp_en_i(1'b1), .guest_irq_i(irq1),
        .csr_we_i(we1), .csr_addr_i(addr1), .csr_wdata_i(wd1), .csr_rdata_o(rd1),
        .vgein_i(3'd0), .view_hvip_i(1'b0), .geilen_o(gl1), .sgeip_o(sge1),
        .vseip_raw_o(vraw1), .vseip_view_o(vview1)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr0(input logic a, input logic [63:0] d);
        we0 = 1'b1; addr0 = a; wd0 = d;
        tick();
        we0 = 1'b0;
    endtask

    task automatic rd0_chk(input string req, input string what, input logic a, input logic [63:0] exp);
        addr0 = a;
        #1;
        chk(req, what, rd0, exp);
    endtask

    task automatic t_reset();
        rd0_chk("R1", "enable after reset", 1'b0, 64'h0);
        rd0_chk("R1", "pending after reset", 1'b1, 64'h0);
        chk("R1", "sgeip after reset", {63'h0, sge0}, 64'h0);
        chk("R1", "vseip after reset", {62'h0, vraw0, vview0}, 64'h0);
        chk("R9", "geilen default", {58'h0, gl0}, 64'd8);
    endtask

    task automatic t_enable_mask();
        wr0(1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
        rd0_chk("R2", "enable all-ones masked", 1'b0, 64'h1FE);
        wr0(1'b0, 64'h1);
        rd0_chk("R2", "enable bit0 dropped", 1'b0, 64'h0);
        wr0(1'b0, 64'h0000_0000_0000_0A04);
        rd0_chk("R2", "enable mixed", 1'b0, 64'h004);
    endtask

    task automatic t_pend_ro();
        irq0 = 8'h00;
        tick();
        wr0(1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
        rd0_chk("R3", "pending after write", 1'b1, 64'h0);
        rd0_chk("R3", "enable unaffected", 1'b0, 64'h004);
    endtask

    task automatic t_lines();
        wr0(1'b0, 64'h0);
        irq0 = 8'hA5;
        rd0_chk("R4", "pending before edge", 1'b1, 64'h0);
        tick();
        rd0_chk("R4", "pending after edge", 1'b1, 64'h14A);
        irq0 = 8'h00;
        tick();
        rd0_chk("R4", "pending falls", 1'b1, 64'h0);
    endtask

    task automatic t_sgeip();
        wr0(1'b0, 64'h004);
        chk("R5", "sgeip enable only", {63'h0, sge0}, 64'h0);
        irq0 = 8'h02;
        tick();
        chk("R5", "sgeip both set", {63'h0, sge0}, 64'h1);
        wr0(1'b0, 64'h008);
        chk("R5", "sgeip after enable move", {63'h0, sge0}, 64'h0);
        wr0(1'b0, 64'h00C);
        chk("R5", "sgeip enable restored", {63'h0, sge0}, 64'h1);
        irq0 = 8'h00;
        tick();
        chk("R5", "sgeip line drop", {63'h0, sge0}, 64'h0);
    endtask

    task automatic t_select();
        irq0 = 8'h82;
        tick();
        vg0 = 6'd2; #1;
        chk("R6", "select bit 2", {63'h0, vraw0}, 64'h1);
        vg0 = 6'd3; #1;
        chk("R6", "select bit 3 clear", {63'h0, vraw0}, 64'h0);
        vg0 = 6'd8; #1;
        chk("R6", "select top bit", {63'h0, vraw0}, 64'h1);
        vg0 = 6'd0; #1;
        chk("R6", "select zero", {63'h0, vraw0}, 64'h0);
        vg0 = 6'd9; #1;
        chk("R6", "select beyond", {63'h0, vraw0}, 64'h0);
    endtask

    task automatic t_view();
        vg0 = 6'd2; hv0 = 1'b0; #1;
        chk("R7", "view normal path", {63'h0, vview0}, 64'h1);
        hv0 = 1'b1; #1;
        chk("R7", "view hvip path", {63'h0, vview0}, 64'h0);
        chk("R7", "raw unaffected", {63'h0, vraw0}, 64'h1);
        hv0 = 1'b0;
        irq0 = 8'h00;
        tick();
    endtask

    task automatic t_hyp_off();
        hyp0 = 1'b0;
        irq0 = 8'hFF;
        #1;
        chk("R8", "geilen off", {58'h0, gl0}, 64'h0);
        tick();
        rd0_chk("R8", "pending off", 1'b1, 64'h0);
        wr0(1'b0, 64'h1FE);
        rd0_chk("R8", "enable write off", 1'b0, 64'h0);
        chk("R8", "sgeip off", {63'h0, sge0}, 64'h0);
        hyp0 = 1'b1;
        irq0 = 8'h00;
        tick();
    endtask

    task automatic t_clamp();
        chk("R9", "geilen clamped", {61'h0, gl1}, 64'd7);
        irq1 = 10'h3FF;
        tick();
        addr1 = 1'b1; #1;
        chk("R9", "pending clamped", {56'h0, rd1}, 64'hFE);
        we1 = 1'b1; addr1 = 1'b0; wd1 = 8'hFF;
        tick();
        we1 = 1'b0; #1;
        chk("R9", "enable clamped", {56'h0, rd1}, 64'hFE);
        chk("R9", "sgeip clamp inst", {63'h0, sge1}, 64'h1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        #1;
        t_reset();
        t_enable_mask();
        t_pend_ro();
        t_lines();
        t_sgeip();
        t_select();
        t_view();
        t_hyp_off();
        t_clamp();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule